// File: doc/BRIEF.md
# SPI Command Frame Engine with CRC32

This block runs one complete command/response exchange over a four-wire SPI link. It acts as the bus master. The host gives it three lengths: the command length, the total transfer length and the length of a received payload that is covered by a CRC. It then reads the command bytes through a small fetch port (address out, byte in). On the wire it sends the command, then a CRC32 of the command, then zero filler until the transfer length is reached. It keeps every byte shifted in from the device.

When the last bit has moved, the engine checks the status byte that the device puts near the end of the frame. If a payload length was given, it also checks the payload CRC. It then raises `done` for one cycle. At that moment `err_mask` holds an error bitmask and `work_ok` holds an acceptance flag, and both stay put until the next start. The received bytes can be read back at any time through a separate read port. A request whose lengths cannot hold the frame is refused with no bus activity. Retries and the meaning of the commands are left to the host.

Top module: `spi_frame_engine`

## Requirements
- R1: The transmitted frame is built in this order: the `send_len` command bytes in order; then four bytes of a CRC32 computed over exactly those bytes, sent most significant byte first; then bytes of 0x00 until `xfer_len` bytes have been sent. The CRC32 uses the reflected polynomial 0xEDB88320, an initial value of 0xFFFFFFFF and a final inversion.
- R2: The link runs in SPI mode 0. `sclk` idles low. `mosi` changes only while `sclk` is low, and each bit is held for a whole high phase. `miso` is sampled on the rising edge. Bits go most significant first. `cs_n` stays low for the whole transfer, which has exactly `xfer_len`×8 rising edges.
- R3: Received byte n (counted from 0) is stored at index n. It can be read on `rd_data` when `rd_addr` = n.
- R4: The status byte is received byte `xfer_len`−4. If this byte, with bits 2 and 5 cleared, is not equal to 0x81, `err_mask` bit 2 is set.
- R5: If status bit 5 is set, `err_mask` bit 0 is set.
- R6: When `rx_len` L > 0, a CRC32 (same algorithm as R1) is computed over received bytes 4 to 3+L. It is compared with received bytes 4+L to 7+L, read most significant byte first. A mismatch sets `err_mask` bit 1. When L = 0, no such check is made.
- R7: A start is refused in any of these cases: `xfer_len` < `send_len`+8; or L > 0 and `xfer_len` < L+12; or `xfer_len` > MAX_BYTES. A refused start pulses `done` on the next cycle with `err_mask` = 0x80000000 and `work_ok` = 0, and `cs_n` never falls. A request exactly at the minimum length is accepted.
- R8: `work_ok` is 1 only when `err_mask` is zero and status bit 2 is set.
- R9: `done` is a single-cycle pulse. `err_mask` and `work_ok` hold their values until the next accepted or refused start. A `start` that arrives during a transfer is ignored. After reset, `cs_n` = 1, `sclk` = 0, `done` = 0 and `busy` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an exchange when idle |
| send_len | input | LW | Number of command bytes |
| xfer_len | input | LW | Total bytes in the transfer |
| rx_len | input | LW | Length of the CRC-covered receive payload, 0 = no check |
| cmd_addr | output | AW | Index of the command byte being fetched |
| cmd_data | input | 8 | Command byte at `cmd_addr` (combinational lookup) |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| err_mask | output | 32 | Error bits: 0 device saw bad CRC, 1 receive CRC bad, 2 bad status, 31 illegal length |
| work_ok | output | 1 | Device accepted the work and no error occurred |
| rd_addr | input | AW | Receive buffer read index |
| rd_data | output | 8 | Received byte at `rd_addr` |

## Verification
The bench builds the engine with MAX_BYTES = 64 and SCLK_HALF = 3. The 64-byte depth lets one case fill the whole buffer, with the payload CRC window and the status byte both near its end. The 64-byte depth also lets a request of 65 bytes hit the upper length limit. A three-cycle half period gives each `sclk` phase several clock cycles, so the checker can see a `mosi` change that lands in the middle of a high phase. The same setting leaves room to inject a second `start` in the middle of a byte.

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int MAX_BYTES = 64,
  parameter int SCLK_HALF = 2,
  localparam int LW = $clog2(MAX_BYTES + 1),
  localparam int AW = $clog2(MAX_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] send_len,
  input  logic [LW-1:0] xfer_len,
  input  logic [LW-1:0] rx_len,
  output logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_data,
  output logic          sclk,
  output logic          cs_n,
  output logic          mosi,
  input  logic          miso,
  output logic          busy,
  output logic          done,
  output logic [31:0]   err_mask,
  output logic          work_ok,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int EW = LW + 2;
  localparam int DW = $clog2(SCLK_HALF) + 1;
  localparam logic [31:0] POLY = 32'hEDB8_8320;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_EVAL} state_t;

  state_t        state;
  logic [LW-1:0] byte_cnt, s_len, x_len, r_len;
  logic [2:0]    bit_cnt;
  logic [DW-1:0] div_cnt;
  logic          sclk_q;
  logic [7:0]    tx_sh;
  logic [6:0]    rx_sh;
  logic [31:0]   crc_tx, crc_rx, crc_got;
  logic          done_q, acc_q;
  logic [31:0]   err_q;
  logic [7:0]    rx_buf [MAX_BYTES];

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  logic [EW-1:0] bc, sl, xl, rl, in_s, in_x, in_r;
  assign bc   = EW'(byte_cnt);
  assign sl   = EW'(s_len);
  assign xl   = EW'(x_len);
  assign rl   = EW'(r_len);
  assign in_s = EW'(send_len);
  assign in_x = EW'(xfer_len);
  assign in_r = EW'(rx_len);

  logic len_ok;
  assign len_ok = (in_x <= EW'(MAX_BYTES)) && (in_x >= in_s + EW'(8)) &&
                  ((in_r == '0) || (in_x >= in_r + EW'(12)));

  logic [31:0] crc_out;
  logic [7:0]  tx_byte;
  logic [1:0]  crc_k;
  assign crc_out = ~crc_tx;
  assign crc_k   = 2'(bc - sl);
  always_comb begin
    if (bc < sl) tx_byte = cmd_data;
    else if (bc < sl + EW'(4)) begin
      case (crc_k)
        2'd0:    tx_byte = crc_out[31:24];
        2'd1:    tx_byte = crc_out[23:16];
        2'd2:    tx_byte = crc_out[15:8];
        default: tx_byte = crc_out[7:0];
      endcase
    end else tx_byte = 8'h00;
  end

  logic [7:0] rb;
  assign rb = {rx_sh, miso};
  logic in_pay, in_crcw;
  assign in_pay  = (rl != '0) && (bc >= EW'(4)) && (bc < rl + EW'(4));
  assign in_crcw = (rl != '0) && (bc >= rl + EW'(4)) && (bc < rl + EW'(8));

  logic [7:0]  status;
  logic [31:0] err_n;
  assign status = rx_buf[AW'(x_len - LW'(4))];
  always_comb begin
    err_n = '0;
    if ((status & 8'hDB) != 8'h81) err_n[2] = 1'b1;
    if (status[5]) err_n[0] = 1'b1;
    if ((rl != '0) && (crc_got != ~crc_rx)) err_n[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      byte_cnt <= '0; s_len <= '0; x_len <= '0; r_len <= '0;
      bit_cnt <= '0; div_cnt <= '0; sclk_q <= 1'b0;
      tx_sh <= '0; rx_sh <= '0;
      crc_tx <= '1; crc_rx <= '1; crc_got <= '0;
      done_q <= 1'b0; acc_q <= 1'b0; err_q <= '0;
      for (int i = 0; i < MAX_BYTES; i++) rx_buf[i] <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          acc_q <= 1'b0;
          if (len_ok) begin
            s_len <= send_len; x_len <= xfer_len; r_len <= rx_len;
            byte_cnt <= '0;
            crc_tx <= '1; crc_rx <= '1; crc_got <= '0;
            err_q <= '0;
            state <= S_LOAD;
          end else begin
            err_q <= 32'h8000_0000;
            done_q <= 1'b1;
          end
        end
        S_LOAD: begin
          tx_sh <= tx_byte;
          if (bc < sl) crc_tx <= crc_step(crc_tx, cmd_data);
          bit_cnt <= '0;
          div_cnt <= '0;
          sclk_q <= 1'b0;
          state <= S_SHIFT;
        end
        S_SHIFT: begin
          if (div_cnt == DW'(SCLK_HALF - 1)) begin
            div_cnt <= '0;
            sclk_q <= ~sclk_q;
            if (!sclk_q) begin
              rx_sh <= rb[6:0];
              if (bit_cnt == 3'd7) begin
                rx_buf[byte_cnt[AW-1:0]] <= rb;
                if (in_pay) crc_rx <= crc_step(crc_rx, rb);
                if (in_crcw) crc_got <= {crc_got[23:0], rb};
              end
            end else if (bit_cnt == 3'd7) begin
              byte_cnt <= byte_cnt + 1'b1;
              state <= (bc == xl - EW'(1)) ? S_EVAL : S_LOAD;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              tx_sh <= {tx_sh[6:0], 1'b0};
            end
          end else div_cnt <= div_cnt + 1'b1;
        end
        S_EVAL: begin
          err_q <= err_n;
          acc_q <= (err_n == '0) && status[2];
          done_q <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_addr = byte_cnt[AW-1:0];
  assign sclk     = sclk_q;
  assign cs_n     = !(state == S_LOAD || state == S_SHIFT);
  assign mosi     = tx_sh[7];
  assign busy     = (state != S_IDLE);
  assign done     = done_q;
  assign err_mask = err_q;
  assign work_ok  = acc_q;
  assign rd_data  = rx_buf[rd_addr];

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  accept_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && work_ok) |-> (err_mask == 32'h0));
  // R7
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !len_ok) |=> (done && cs_n && err_mask == 32'h8000_0000 && !work_ok));
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(err_mask) && $stable(work_ok)));
endmodule

// File: tb/test_spi_frame_engine.sv
module test_spi_frame_engine;
  localparam int MAXB = 64;
  localparam int LW = $clog2(MAXB + 1);
  localparam int AW = $clog2(MAXB);
  typedef logic [7:0] buf_t [128];

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LW-1:0] send_len = '0, xfer_len = '0, rx_len = '0;
  logic [AW-1:0] cmd_addr, rd_addr = '0;
  logic [7:0] cmd_data, rd_data;
  logic sclk, cs_n, mosi, miso = 1'b0, busy, done, work_ok;
  logic [31:0] err_mask;

  buf_t cmd_mem, resp, txcap;
  int n_tests = 0, n_fail = 0, bp = 0, cs_falls = 0;
  logic [31:0] got_err;
  logic got_ok;

  always #10 clk = ~clk;
  assign cmd_data = cmd_mem[cmd_addr];

  spi_frame_engine #(.MAX_BYTES(MAXB), .SCLK_HALF(3)) i_spi_frame_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .send_len(send_len), .xfer_len(xfer_len),
    .rx_len(rx_len), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .busy(busy), .done(done), .err_mask(err_mask),
    .work_ok(work_ok), .rd_addr(rd_addr), .rd_data(rd_data));

  initial begin
    forever begin
      @(negedge cs_n);
      cs_falls++;
      bp = 0;
      miso = resp[0][7];
      while (!cs_n) begin
        @(posedge sclk or posedge cs_n);
        if (cs_n) break;
        txcap[bp / 8][7 - bp % 8] = mosi;
        bp++;
        @(negedge sclk or posedge cs_n);
        if (cs_n) break;
        miso = resp[bp / 8][7 - bp % 8];
      end
    end
  end

  function automatic logic [31:0] crc_of(input buf_t b, input int off, input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++)
        c = (c[0] ^ b[off + i][k]) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    return ~c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input int seed, input int xl, input logic [7:0] st);
    for (int i = 0; i < 128; i++) begin
      resp[i] = 8'((i * 29 + seed * 13 + 5) ^ (i >> 2));
      txcap[i] = 8'hEE;
    end
    resp[xl - 4] = st;
  endtask

  task automatic run(input int sl, input int xl, input int rl);
    @(negedge clk);
    send_len = LW'(sl); xfer_len = LW'(xl); rx_len = LW'(rl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    got_err = err_mask;
    got_ok = work_ok;
  endtask

  task automatic t_reset;
    chk("R9 reset cs_n", 32'(cs_n), 1);
    chk("R9 reset sclk", 32'(sclk), 0);
    chk("R9 reset done", 32'(done), 0);
    chk("R9 reset busy", 32'(busy), 0);
  endtask

  task automatic t_frame;
    logic [31:0] c;
    cmd_mem[0] = 8'hA5; cmd_mem[1] = 8'h3C; cmd_mem[2] = 8'h01; cmd_mem[3] = 8'hFF;
    fill(1, 16, 8'h81);
    run(4, 16, 0);
    c = crc_of(cmd_mem, 0, 4);
    for (int i = 0; i < 4; i++) chk("R1 cmd byte", 32'(txcap[i]), 32'(cmd_mem[i]));
    for (int i = 0; i < 4; i++) chk("R1 crc byte", 32'(txcap[4 + i]), 32'(c >> (24 - 8 * i)) & 32'hFF);
    for (int i = 8; i < 16; i++) chk("R1 filler", 32'(txcap[i]), 0);
    chk("R2 edge count", 32'(bp), 128);
    chk("R6 no check when L=0", got_err, 0);
    chk("R8 no accept bit", 32'(got_ok), 0);
    for (int i = 0; i < 16; i++) begin
      rd_addr = AW'(i); #1;
      chk("R3 readback", 32'(rd_data), 32'(resp[i]));
    end
  endtask

  task automatic t_status(input logic [7:0] st, input logic [31:0] e, input logic ok, input string tag);
    cmd_mem[0] = st; cmd_mem[1] = 8'h11;
    fill(int'(st), 12, st);
    run(2, 12, 0);
    chk(tag, got_err, e);
    chk({tag, " R8 work_ok"}, 32'(got_ok), 32'(ok));
  endtask

  task automatic t_rxcrc(input bit corrupt);
    logic [31:0] c;
    for (int i = 0; i < 4; i++) cmd_mem[i] = 8'(8'h40 + i);
    fill(corrupt ? 7 : 3, 18, 8'h85);
    c = crc_of(resp, 4, 6);
    for (int i = 0; i < 4; i++) resp[10 + i] = 8'(c >> (24 - 8 * i));
    if (corrupt) resp[12] = resp[12] ^ 8'h10;
    run(4, 18, 6);
    chk(corrupt ? "R6 bad rx crc" : "R6 good rx crc at min length R7", got_err, corrupt ? 2 : 0);
    chk("R8 work_ok rx crc", 32'(got_ok), corrupt ? 0 : 1);
    rd_addr = AW'(11); #1;
    chk("R3 crc byte readback", 32'(rd_data), 32'(resp[11]));
  endtask

  task automatic t_len(input int sl, input int xl, input int rl, input string tag);
    int f = cs_falls;
    run(sl, xl, rl);
    chk(tag, got_err, 32'h8000_0000);
    chk({tag, " R7 no cs"}, 32'(cs_falls), 32'(f));
    chk({tag, " R8"}, 32'(got_ok), 0);
  endtask

  task automatic t_busy;
    for (int i = 0; i < 8; i++) cmd_mem[i] = 8'(i * 3);
    fill(9, 24, 8'h85);
    @(negedge clk);
    send_len = 8; xfer_len = 24; rx_len = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (100) @(negedge clk);
    xfer_len = 12; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    chk("R9 start ignored while busy", 32'(bp), 192);
    chk("R9 result", err_mask, 0);
    repeat (20) @(negedge clk);
    chk("R9 err held", err_mask, 0);
    chk("R9 work_ok held", 32'(work_ok), 1);
  endtask

  task automatic t_max;
    logic [31:0] c, t;
    for (int i = 0; i < 20; i++) cmd_mem[i] = 8'(8'hC0 ^ (i * 7));
    fill(11, 64, 8'hA1);
    c = crc_of(resp, 4, 40);
    for (int i = 0; i < 4; i++) resp[44 + i] = 8'(c >> (24 - 8 * i));
    run(20, 64, 40);
    t = crc_of(cmd_mem, 0, 20);
    chk("R5 max frame", got_err, 1);
    chk("R1 max crc msb", 32'(txcap[20]), t >> 24);
    chk("R1 max filler", 32'(txcap[63]), 0);
    chk("R2 max edges", 32'(bp), 512);
    rd_addr = AW'(63); #1;
    chk("R3 last byte", 32'(rd_data), 32'(resp[63]));
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin cmd_mem[i] = '0; resp[i] = '0; txcap[i] = '0; end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_frame;
    t_status(8'h85, 32'h0, 1'b1, "R8 accepted");
    t_status(8'hA1, 32'h1, 1'b0, "R5 device crc flag");
    t_status(8'hA5, 32'h1, 1'b0, "R5 flag blocks accept");
    t_status(8'h80, 32'h4, 1'b0, "R4 bad status low");
    t_status(8'hC1, 32'h4, 1'b0, "R4 bad status high");
    t_rxcrc(1'b0);
    t_rxcrc(1'b1);
    t_len(4, 11, 0, "R7 short cmd");
    t_len(4, 21, 10, "R7 short payload");
    t_len(4, 65, 0, "R7 over max");
    t_busy;
    t_max;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule